// File: doc/BRIEF.md
# Multicycle Processor Control Sequencer

This block is the control unit of a simple non-pipelined load/store processor. It is a Moore state machine. The current state alone sets every strobe it drives into the datapath: register clock enables, bus driver enables, ALU operation selects, memory read and write, and register-file write controls. The state register advances on each rising clock edge. The next state depends on the opcode and function fields of the instruction register, on a memory busy flag and on a zero flag for the A operand.

Each instruction class follows a fixed path of states, and every path starts with fetch and decode:

| Class | States after decode |
|---|---|
| Register ALU operation | one execute state, then an R-type write-back |
| Shift | one execute state, then an R-type write-back |
| Immediate ALU operation | one execute state, then an I-type write-back |
| Immediate test | one execute state, then an I-type write-back |
| Load | four states |
| Store | three states |
| Conditional branch | a test state, then an optional taken state |
| Register jump | one state |
| Jump-and-link | two states |

The controller holds in the fetch, load-access and store-access states while the memory reports busy.

The datapath sits beside this block. It uses the strobes and it reads the ALU and shift details from the instruction register directly. It returns only the zero flag of A.

Top module: `mc_ctrl_fsm`

## Requirements
- R1: A synchronous active-high `rst` puts the controller in the fetch state at the next rising edge. This holds from any state.
- R2: In fetch only `ir_ce`, `pc_adr_oe` and `mem_rd` are high. The state stays fetch on every edge where `mem_busy` is 1. It moves to decode on the first edge where `mem_busy` is 0.
- R3: In decode only these strobes are high: `a_ce`, `b_ce`, `s1_pc`, `s2_one`, `alu_add`, `alu_oe` and `pc_ce`.
- R4: Opcode 000000 with `func[5]`=1 is a register ALU operation. Its execute state drives only `s1_a`, `s2_b`, `alu_op`, `alu_oe` and `c_ce`. Next comes an R-type write-back with only `gpr_we` high, and then fetch.
- R5: Opcode 000000 with `func` 000100 (right) or 000110 (left) is a shift, and `func[1]`=1 selects left. The shift state drives only `s1_a`, `shift_en`, `c_ce` and `shift_left`, the last one equal to `func[1]`. Next comes the R-type write-back, and then fetch.
- R6: An opcode whose top bits are 010 is an immediate ALU operation. Its execute state drives `s1_a`, `s2_imm`, `alu_op`, `alu_oe` and `c_ce`. Next comes an I-type write-back with only `gpr_we` and `itype` high, and then fetch.
- R7: An opcode whose top bits are 011 is an immediate test. Its execute state drives `s1_a`, `s2_imm`, `alu_test`, `alu_oe` and `c_ce`. Next comes the I-type write-back, and then fetch.
- R8: Opcode 100011 is a load. Its states run in this order:
  - Address compute, with `s1_a`, `s2_imm`, `alu_add`, `alu_oe` and `mar_ce` high.
  - Memory access, with `mem_rd`, `mdr_ce`, `mdr_from_mem` and `mar_adr_oe` high. This state holds while `mem_busy` is 1.
  - MDR to C, with `s1_mdr`, `s2_zero`, `alu_add`, `alu_oe` and `c_ce` high.
  - I-type write-back.
- R9: Opcode 101011 is a store. Its states run in this order:
  - Address compute.
  - B to MDR, with only `s2_b` and `mdr_ce` high.
  - Memory write, with only `mar_adr_oe` and `mem_wr` high. This state holds while `mem_busy` is 1.
  - Fetch.
- R10: Opcodes 000100 (branch if zero) and 000101 (branch if nonzero) enter a test state with only `s1_a`, `s2_zero` and `alu_test` high. If the branch is taken, a taken state follows with `s1_pc`, `s2_imm`, `alu_add`, `alu_oe` and `pc_ce` high, and then fetch. If it is not taken, fetch follows directly.
- R11: Opcode 000110 is a register jump. Its one state drives `s1_a`, `s2_zero`, `alu_add`, `alu_oe` and `pc_ce`, and fetch follows. Opcode 000111 is jump-and-link, which runs two states and then fetch:
  - Save PC, with `s1_pc`, `s2_zero`, `alu_add`, `alu_oe` and `c_ce` high.
  - Link, with the register-jump strobes plus `gpr_we` and `jlink`.
- R12: Any other opcode/function pair goes from decode straight back to fetch. It raises no `gpr_we`, `c_ce`, `mar_ce` or `mem_wr` on the way.
- R13: In every state at most one of `s1_pc`, `s1_a`, `s1_mdr` is high. At most one of `s2_b`, `s2_imm`, `s2_zero`, `s2_one` is high. `mem_rd` and `mem_wr` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| opcode | input | 6 | Opcode field of the instruction register |
| func | input | 6 | Function field of the instruction register |
| mem_busy | input | 1 | Memory still completing the current read or write |
| a_zero | input | 1 | A operand equals zero |
| ir_ce | output | 1 | Instruction register clock enable |
| pc_ce | output | 1 | PC clock enable |
| a_ce | output | 1 | A register clock enable |
| b_ce | output | 1 | B register clock enable |
| c_ce | output | 1 | C register clock enable |
| mar_ce | output | 1 | Memory address register clock enable |
| mdr_ce | output | 1 | Memory data register clock enable |
| mdr_from_mem | output | 1 | MDR input taken from memory data out |
| pc_adr_oe | output | 1 | PC drives the memory address |
| mar_adr_oe | output | 1 | MAR drives the memory address |
| s1_pc | output | 1 | PC drives bus S1 |
| s1_a | output | 1 | A drives bus S1 |
| s1_mdr | output | 1 | MDR drives bus S1 |
| s2_b | output | 1 | B drives bus S2 |
| s2_imm | output | 1 | Sign-extended immediate drives bus S2 |
| s2_zero | output | 1 | Constant 0 drives bus S2 |
| s2_one | output | 1 | Constant 1 drives bus S2 |
| alu_oe | output | 1 | ALU result drives the internal result bus |
| alu_add | output | 1 | ALU forced to add |
| alu_op | output | 1 | ALU operation taken from the instruction |
| alu_test | output | 1 | ALU in compare mode |
| shift_en | output | 1 | Shifter result selected into C |
| shift_left | output | 1 | Shift direction, 1 is left |
| mem_rd | output | 1 | Memory read request |
| mem_wr | output | 1 | Memory write request |
| gpr_we | output | 1 | Register file write enable |
| itype | output | 1 | Write-back target taken from the I-type field |
| jlink | output | 1 | Write-back target forced to the link register |

## Verification
Every strobe is a function of the state register alone. A decision taken at a rising edge therefore shows on the outputs in the same clock period, one register after the inputs that drove it. Those inputs are the opcode class at the end of decode, `mem_busy` at the end of a fetch or access cycle, and `a_zero` at the end of the branch test.

The bench changes inputs on the falling edge and checks the full strobe vector at the next falling edge, one state per period. A busy stretch of N cycles must therefore show as exactly N+1 identical vectors before the path moves on. Reset applied in the middle of a path must show fetch in the very next period.

// File: rtl/mcc_pkg.sv
package mcc_pkg;

   localparam int OPC_W  = 6;
   localparam int FUNC_W = 6;

   localparam logic [OPC_W-1:0] OPC_RTYPE = 6'b000000;
   localparam logic [OPC_W-1:0] OPC_BEQZ  = 6'b000100;
   localparam logic [OPC_W-1:0] OPC_BNEZ  = 6'b000101;
   localparam logic [OPC_W-1:0] OPC_JR    = 6'b000110;
   localparam logic [OPC_W-1:0] OPC_JALR  = 6'b000111;
   localparam logic [OPC_W-1:0] OPC_LW    = 6'b100011;
   localparam logic [OPC_W-1:0] OPC_SW    = 6'b101011;
   localparam logic [2:0]       GRP_ALUI  = 3'b010;
   localparam logic [2:0]       GRP_TESTI = 3'b011;

   typedef enum logic [4:0] {
      ST_FETCH, ST_DECODE, ST_ALU, ST_ALUI, ST_SHIFT, ST_TESTI,
      ST_ADDR, ST_LOAD, ST_MDR2C, ST_GPR2MDR, ST_STORE,
      ST_BRANCH, ST_BTAKEN, ST_JR, ST_SAVEPC, ST_JALR,
      ST_WBR, ST_WBI
   } state_e;

   typedef enum logic [3:0] {
      CL_NONE, CL_ALU, CL_SHIFT, CL_ALUI, CL_TESTI, CL_LOAD,
      CL_STORE, CL_BEQZ, CL_BNEZ, CL_JR, CL_JALR
   } iclass_e;

   typedef struct packed {
      logic ir_ce;
      logic pc_ce;
      logic a_ce;
      logic b_ce;
      logic c_ce;
      logic mar_ce;
      logic mdr_ce;
      logic mdr_from_mem;
      logic pc_adr_oe;
      logic mar_adr_oe;
      logic s1_pc;
      logic s1_a;
      logic s1_mdr;
      logic s2_b;
      logic s2_imm;
      logic s2_zero;
      logic s2_one;
      logic alu_oe;
      logic alu_add;
      logic alu_op;
      logic alu_test;
      logic shift_en;
      logic shift_left;
      logic mem_rd;
      logic mem_wr;
      logic gpr_we;
      logic itype;
      logic jlink;
   } strobe_t;

endpackage

// File: rtl/mcc_idec.sv
module mcc_idec
   import mcc_pkg::*;
(
   input  logic [OPC_W-1:0]  opcode,
   input  logic [FUNC_W-1:0] func,
   output iclass_e           cls,
   output logic              shift_left
);

   always_comb begin
      cls = CL_NONE;
      if (opcode == OPC_RTYPE) begin
         if (func[5])
            cls = CL_ALU;
         else if ({func[5:2], func[0]} == 5'b00010)
            cls = CL_SHIFT;
      end else if (opcode[5:3] == GRP_ALUI) begin
         cls = CL_ALUI;
      end else if (opcode[5:3] == GRP_TESTI) begin
         cls = CL_TESTI;
      end else begin
         case (opcode)
            OPC_LW:   cls = CL_LOAD;
            OPC_SW:   cls = CL_STORE;
            OPC_BEQZ: cls = CL_BEQZ;
            OPC_BNEZ: cls = CL_BNEZ;
            OPC_JR:   cls = CL_JR;
            OPC_JALR: cls = CL_JALR;
            default:  cls = CL_NONE;
         endcase
      end
   end

   assign shift_left = func[1];

endmodule

// File: rtl/mcc_nsl.sv
module mcc_nsl
   import mcc_pkg::*;
(
   input  state_e  state,
   input  iclass_e cls,
   input  logic    mem_busy,
   input  logic    a_zero,
   output state_e  next
);

   logic taken;
   assign taken = (cls == CL_BEQZ) ? a_zero : !a_zero;

   always_comb begin
      next = ST_FETCH;
      case (state)
         ST_FETCH:   next = mem_busy ? ST_FETCH : ST_DECODE;
         ST_DECODE: begin
            case (cls)
               CL_ALU:              next = ST_ALU;
               CL_SHIFT:            next = ST_SHIFT;
               CL_ALUI:             next = ST_ALUI;
               CL_TESTI:            next = ST_TESTI;
               CL_LOAD, CL_STORE:   next = ST_ADDR;
               CL_BEQZ, CL_BNEZ:    next = ST_BRANCH;
               CL_JR:               next = ST_JR;
               CL_JALR:             next = ST_SAVEPC;
               default:             next = ST_FETCH;
            endcase
         end
         ST_ALU, ST_SHIFT:    next = ST_WBR;
         ST_ALUI, ST_TESTI:   next = ST_WBI;
         ST_ADDR:    next = (cls == CL_LOAD) ? ST_LOAD : ST_GPR2MDR;
         ST_LOAD:    next = mem_busy ? ST_LOAD : ST_MDR2C;
         ST_MDR2C:   next = ST_WBI;
         ST_GPR2MDR: next = ST_STORE;
         ST_STORE:   next = mem_busy ? ST_STORE : ST_FETCH;
         ST_BRANCH:  next = taken ? ST_BTAKEN : ST_FETCH;
         ST_SAVEPC:  next = ST_JALR;
         default:    next = ST_FETCH;
      endcase
   end

endmodule

// File: rtl/mcc_strobe.sv
module mcc_strobe
   import mcc_pkg::*;
(
   input  state_e  state,
   input  logic    shift_dir,
   output strobe_t s
);

   always_comb begin
      s = '0;
      case (state)
         ST_FETCH: begin
            s.ir_ce = 1'b1; s.pc_adr_oe = 1'b1; s.mem_rd = 1'b1;
         end
         ST_DECODE: begin
            s.a_ce = 1'b1; s.b_ce = 1'b1; s.s1_pc = 1'b1; s.s2_one = 1'b1;
            s.alu_add = 1'b1; s.alu_oe = 1'b1; s.pc_ce = 1'b1;
         end
         ST_ALU: begin
            s.s1_a = 1'b1; s.s2_b = 1'b1; s.alu_op = 1'b1;
            s.alu_oe = 1'b1; s.c_ce = 1'b1;
         end
         ST_ALUI: begin
            s.s1_a = 1'b1; s.s2_imm = 1'b1; s.alu_op = 1'b1;
            s.alu_oe = 1'b1; s.c_ce = 1'b1;
         end
         ST_SHIFT: begin
            s.s1_a = 1'b1; s.shift_en = 1'b1; s.shift_left = shift_dir;
            s.c_ce = 1'b1;
         end
         ST_TESTI: begin
            s.s1_a = 1'b1; s.s2_imm = 1'b1; s.alu_test = 1'b1;
            s.alu_oe = 1'b1; s.c_ce = 1'b1;
         end
         ST_ADDR: begin
            s.s1_a = 1'b1; s.s2_imm = 1'b1; s.alu_add = 1'b1;
            s.alu_oe = 1'b1; s.mar_ce = 1'b1;
         end
         ST_LOAD: begin
            s.mem_rd = 1'b1; s.mdr_ce = 1'b1; s.mdr_from_mem = 1'b1;
            s.mar_adr_oe = 1'b1;
         end
         ST_MDR2C: begin
            s.s1_mdr = 1'b1; s.s2_zero = 1'b1; s.alu_add = 1'b1;
            s.alu_oe = 1'b1; s.c_ce = 1'b1;
         end
         ST_GPR2MDR: begin
            s.s2_b = 1'b1; s.mdr_ce = 1'b1;
         end
         ST_STORE: begin
            s.mar_adr_oe = 1'b1; s.mem_wr = 1'b1;
         end
         ST_BRANCH: begin
            s.s1_a = 1'b1; s.s2_zero = 1'b1; s.alu_test = 1'b1;
         end
         ST_BTAKEN: begin
            s.s1_pc = 1'b1; s.s2_imm = 1'b1; s.alu_add = 1'b1;
            s.alu_oe = 1'b1; s.pc_ce = 1'b1;
         end
         ST_JR: begin
            s.s1_a = 1'b1; s.s2_zero = 1'b1; s.alu_add = 1'b1;
            s.alu_oe = 1'b1; s.pc_ce = 1'b1;
         end
         ST_SAVEPC: begin
            s.s1_pc = 1'b1; s.s2_zero = 1'b1; s.alu_add = 1'b1;
            s.alu_oe = 1'b1; s.c_ce = 1'b1;
         end
         ST_JALR: begin
            s.s1_a = 1'b1; s.s2_zero = 1'b1; s.alu_add = 1'b1;
            s.alu_oe = 1'b1; s.pc_ce = 1'b1; s.gpr_we = 1'b1; s.jlink = 1'b1;
         end
         ST_WBR: s.gpr_we = 1'b1;
         ST_WBI: begin
            s.gpr_we = 1'b1; s.itype = 1'b1;
         end
         default: s = '0;
      endcase
   end

endmodule

// File: rtl/mc_ctrl_fsm.sv
module mc_ctrl_fsm
   import mcc_pkg::*;
#(
   parameter int OPCODE_BITS = 6,
   parameter int FUNC_BITS   = 6
) (
   input  logic                   clk,
   input  logic                   rst,
   input  logic [OPCODE_BITS-1:0] opcode,
   input  logic [FUNC_BITS-1:0]   func,
   input  logic                   mem_busy,
   input  logic                   a_zero,
   output logic                   ir_ce,
   output logic                   pc_ce,
   output logic                   a_ce,
   output logic                   b_ce,
   output logic                   c_ce,
   output logic                   mar_ce,
   output logic                   mdr_ce,
   output logic                   mdr_from_mem,
   output logic                   pc_adr_oe,
   output logic                   mar_adr_oe,
   output logic                   s1_pc,
   output logic                   s1_a,
   output logic                   s1_mdr,
   output logic                   s2_b,
   output logic                   s2_imm,
   output logic                   s2_zero,
   output logic                   s2_one,
   output logic                   alu_oe,
   output logic                   alu_add,
   output logic                   alu_op,
   output logic                   alu_test,
   output logic                   shift_en,
   output logic                   shift_left,
   output logic                   mem_rd,
   output logic                   mem_wr,
   output logic                   gpr_we,
   output logic                   itype,
   output logic                   jlink
);

   if (OPCODE_BITS != OPC_W) begin : g_bad_opcode_width
      $error("mc_ctrl_fsm: OPCODE_BITS must match the package opcode width");
   end
   if (FUNC_BITS != FUNC_W) begin : g_bad_func_width
      $error("mc_ctrl_fsm: FUNC_BITS must match the package function width");
   end

   state_e  state_q, state_d;
   iclass_e cls;
   logic    dir_left;
   strobe_t stb;

   mcc_idec u_idec (
      .opcode     (opcode),
      .func       (func),
      .cls        (cls),
      .shift_left (dir_left)
   );

   mcc_nsl u_nsl (
      .state    (state_q),
      .cls      (cls),
      .mem_busy (mem_busy),
      .a_zero   (a_zero),
      .next     (state_d)
   );

   always_ff @(posedge clk) begin
      if (rst) state_q <= ST_FETCH;
      else     state_q <= state_d;
   end

   mcc_strobe u_strobe (
      .state     (state_q),
      .shift_dir (dir_left),
      .s         (stb)
   );

   assign ir_ce        = stb.ir_ce;
   assign pc_ce        = stb.pc_ce;
   assign a_ce         = stb.a_ce;
   assign b_ce         = stb.b_ce;
   assign c_ce         = stb.c_ce;
   assign mar_ce       = stb.mar_ce;
   assign mdr_ce       = stb.mdr_ce;
   assign mdr_from_mem = stb.mdr_from_mem;
   assign pc_adr_oe    = stb.pc_adr_oe;
   assign mar_adr_oe   = stb.mar_adr_oe;
   assign s1_pc        = stb.s1_pc;
   assign s1_a         = stb.s1_a;
   assign s1_mdr       = stb.s1_mdr;
   assign s2_b         = stb.s2_b;
   assign s2_imm       = stb.s2_imm;
   assign s2_zero      = stb.s2_zero;
   assign s2_one       = stb.s2_one;
   assign alu_oe       = stb.alu_oe;
   assign alu_add      = stb.alu_add;
   assign alu_op       = stb.alu_op;
   assign alu_test     = stb.alu_test;
   assign shift_en     = stb.shift_en;
   assign shift_left   = stb.shift_left;
   assign mem_rd       = stb.mem_rd;
   assign mem_wr       = stb.mem_wr;
   assign gpr_we       = stb.gpr_we;
   assign itype        = stb.itype;
   assign jlink        = stb.jlink;

endmodule

// File: rtl/mcc_ctrl_chk.sv
module mcc_ctrl_chk (
   input logic clk,
   input logic rst,
   input logic mem_busy,
   input logic ir_ce,
   input logic pc_ce,
   input logic s1_pc,
   input logic s1_a,
   input logic s1_mdr,
   input logic s2_b,
   input logic s2_imm,
   input logic s2_zero,
   input logic s2_one,
   input logic mem_rd,
   input logic mem_wr,
   input logic gpr_we,
   input logic itype,
   input logic jlink
);

   a_r1_reset_to_fetch: assert property (@(posedge clk)
      rst |=> (ir_ce && mem_rd && !gpr_we && !mem_wr));

   a_r2_fetch_hold: assert property (@(posedge clk) disable iff (rst)
      (ir_ce && mem_busy) |=> ir_ce);

   a_r2_fetch_leave: assert property (@(posedge clk) disable iff (rst)
      (ir_ce && !mem_busy) |=> !ir_ce);

   a_r8_load_hold: assert property (@(posedge clk) disable iff (rst)
      (mem_rd && !ir_ce && mem_busy) |=> (mem_rd && !ir_ce));

   a_r9_store_hold: assert property (@(posedge clk) disable iff (rst)
      (mem_wr && mem_busy) |=> mem_wr);

   a_r9_store_done: assert property (@(posedge clk) disable iff (rst)
      (mem_wr && !mem_busy) |=> ir_ce);

   a_r11_link_write: assert property (@(posedge clk) disable iff (rst)
      (gpr_we && jlink) |-> (pc_ce && !itype));

   a_r13_s1_single: assert property (@(posedge clk) disable iff (rst)
      $onehot0({s1_pc, s1_a, s1_mdr}));

   a_r13_s2_single: assert property (@(posedge clk) disable iff (rst)
      $onehot0({s2_b, s2_imm, s2_zero, s2_one}));

   a_r13_mem_excl: assert property (@(posedge clk) disable iff (rst)
      !(mem_rd && mem_wr));

endmodule

bind mc_ctrl_fsm mcc_ctrl_chk u_chk (.*);

// File: tb/mc_ctrl_fsm_tb.sv
module mc_ctrl_fsm_tb;

   localparam int F = 0, D = 1, ALU = 2, ALUI = 3, SH = 4, TI = 5, AC = 6,
                  LD = 7, M2C = 8, G2M = 9, STO = 10, BR = 11, BT = 12,
                  JR = 13, SPC = 14, JL = 15, WBR = 16, WBI = 17;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic [5:0] opcode = '0;
   logic [5:0] func = '0;
   logic mem_busy = 1'b0;
   logic a_zero = 1'b0;

   logic ir_ce, pc_ce, a_ce, b_ce, c_ce, mar_ce, mdr_ce, mdr_from_mem;
   logic pc_adr_oe, mar_adr_oe, s1_pc, s1_a, s1_mdr, s2_b, s2_imm, s2_zero, s2_one;
   logic alu_oe, alu_add, alu_op, alu_test, shift_en, shift_left;
   logic mem_rd, mem_wr, gpr_we, itype, jlink;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   mc_ctrl_fsm u_dut (
      .clk(clk), .rst(rst), .opcode(opcode), .func(func),
      .mem_busy(mem_busy), .a_zero(a_zero),
      .ir_ce(ir_ce), .pc_ce(pc_ce), .a_ce(a_ce), .b_ce(b_ce), .c_ce(c_ce),
      .mar_ce(mar_ce), .mdr_ce(mdr_ce), .mdr_from_mem(mdr_from_mem),
      .pc_adr_oe(pc_adr_oe), .mar_adr_oe(mar_adr_oe),
      .s1_pc(s1_pc), .s1_a(s1_a), .s1_mdr(s1_mdr),
      .s2_b(s2_b), .s2_imm(s2_imm), .s2_zero(s2_zero), .s2_one(s2_one),
      .alu_oe(alu_oe), .alu_add(alu_add), .alu_op(alu_op), .alu_test(alu_test),
      .shift_en(shift_en), .shift_left(shift_left),
      .mem_rd(mem_rd), .mem_wr(mem_wr), .gpr_we(gpr_we), .itype(itype),
      .jlink(jlink)
   );

   wire [27:0] obs = {ir_ce, pc_ce, a_ce, b_ce, c_ce, mar_ce, mdr_ce, mdr_from_mem,
                      pc_adr_oe, mar_adr_oe, s1_pc, s1_a, s1_mdr,
                      s2_b, s2_imm, s2_zero, s2_one,
                      alu_oe, alu_add, alu_op, alu_test, shift_en, shift_left,
                      mem_rd, mem_wr, gpr_we, itype, jlink};

   // Expected strobe set of each state, written from the requirements.
   function automatic logic [27:0] exp_vec(input int st, input logic left);
      logic ir, pc, a, b, c, mar, mdr, mdrm, pco, maro, p1, a1, m1;
      logic b2, i2, z2, o2, aoe, add, op, tst, sh, shl, rd, wr, we, it, jl;
      {ir, pc, a, b, c, mar, mdr, mdrm, pco, maro, p1, a1, m1} = '0;
      {b2, i2, z2, o2, aoe, add, op, tst, sh, shl, rd, wr, we, it, jl} = '0;
      case (st)
         F:   begin ir = 1; pco = 1; rd = 1; end                              // R2
         D:   begin a = 1; b = 1; p1 = 1; o2 = 1; add = 1; aoe = 1; pc = 1; end // R3
         ALU: begin a1 = 1; b2 = 1; op = 1; aoe = 1; c = 1; end               // R4
         ALUI:begin a1 = 1; i2 = 1; op = 1; aoe = 1; c = 1; end               // R6
         SH:  begin a1 = 1; sh = 1; shl = left; c = 1; end                    // R5
         TI:  begin a1 = 1; i2 = 1; tst = 1; aoe = 1; c = 1; end              // R7
         AC:  begin a1 = 1; i2 = 1; add = 1; aoe = 1; mar = 1; end            // R8
         LD:  begin rd = 1; mdr = 1; mdrm = 1; maro = 1; end
         M2C: begin m1 = 1; z2 = 1; add = 1; aoe = 1; c = 1; end
         G2M: begin b2 = 1; mdr = 1; end                                      // R9
         STO: begin maro = 1; wr = 1; end
         BR:  begin a1 = 1; z2 = 1; tst = 1; end                              // R10
         BT:  begin p1 = 1; i2 = 1; add = 1; aoe = 1; pc = 1; end
         JR:  begin a1 = 1; z2 = 1; add = 1; aoe = 1; pc = 1; end             // R11
         SPC: begin p1 = 1; z2 = 1; add = 1; aoe = 1; c = 1; end
         JL:  begin a1 = 1; z2 = 1; add = 1; aoe = 1; pc = 1; we = 1; jl = 1; end
         WBR: we = 1;
         WBI: begin we = 1; it = 1; end
         default: ;
      endcase
      return {ir, pc, a, b, c, mar, mdr, mdrm, pco, maro, p1, a1, m1,
              b2, i2, z2, o2, aoe, add, op, tst, sh, shl, rd, wr, we, it, jl};
   endfunction

   // Called just after a falling edge: checks the strobes of the current state.
   task automatic expect_st(input int st, input string req, input logic left = 1'b0);
      logic [27:0] e;
      e = exp_vec(st, left);
      checks++;
      if (obs !== e) begin
         errors++;
         $display("FAIL %s state %0d: actual %b expected %b", req, st, obs, e);
      end
      checks++;
      if (!$onehot0({s1_pc, s1_a, s1_mdr}) || !$onehot0({s2_b, s2_imm, s2_zero, s2_one})
          || (mem_rd && mem_wr)) begin
         errors++;
         $display("FAIL R13 bus drivers: actual s1=%b s2=%b rw=%b%b expected at most one each",
                  {s1_pc, s1_a, s1_mdr}, {s2_b, s2_imm, s2_zero, s2_one}, mem_rd, mem_wr);
      end
   endtask

   task automatic tick;
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic step(input int st, input string req, input logic left = 1'b0);
      expect_st(st, req, left);
      tick();
   endtask

   // A state that waits on busy: nb busy cycles, then one cycle with busy low.
   task automatic busy_state(input int st, input int nb, input string req);
      for (int i = 0; i < nb; i++) begin
         mem_busy = 1'b1;
         step(st, req);
      end
      mem_busy = 1'b0;
      step(st, req);
   endtask

   task automatic start(input logic [5:0] opc, input logic [5:0] fn, input int fb);
      opcode = opc;
      func   = fn;
      busy_state(F, fb, "R2");
      step(D, "R3");
   endtask

   task automatic t_reset_initial;
      @(negedge clk);
      expect_st(F, "R1");
      rst = 1'b0;
   endtask

   task automatic t_alu_reg;
      start(6'b000000, 6'b100010, 0);
      step(ALU, "R4");
      step(WBR, "R4");
   endtask

   task automatic t_shift(input logic left);
      start(6'b000000, left ? 6'b000110 : 6'b000100, 1);
      step(SH, "R5", left);
      step(WBR, "R5");
   endtask

   task automatic t_alui;
      start(6'b010011, 6'b000000, 0);
      step(ALUI, "R6");
      step(WBI, "R6");
   endtask

   task automatic t_testi;
      start(6'b011101, 6'b000000, 0);
      step(TI, "R7");
      step(WBI, "R7");
   endtask

   task automatic t_load(input int fb, input int lb);
      start(6'b100011, 6'b000000, fb);
      step(AC, "R8");
      busy_state(LD, lb, "R8");
      step(M2C, "R8");
      step(WBI, "R8");
   endtask

   task automatic t_store(input int sb);
      start(6'b101011, 6'b000000, 0);
      step(AC, "R9");
      step(G2M, "R9");
      busy_state(STO, sb, "R9");
   endtask

   task automatic t_branch(input logic [5:0] opc, input logic az, input bit taken);
      a_zero = az;
      start(opc, 6'b000000, 0);
      step(BR, "R10");
      if (taken) step(BT, "R10");
   endtask

   task automatic t_jr;
      start(6'b000110, 6'b000000, 0);
      step(JR, "R11");
   endtask

   task automatic t_jalr;
      start(6'b000111, 6'b000000, 0);
      step(SPC, "R11");
      step(JL, "R11");
   endtask

   task automatic t_unknown(input logic [5:0] opc, input logic [5:0] fn);
      start(opc, fn, 0);
      expect_st(F, "R12");
   endtask

   task automatic t_reset_mid;
      start(6'b100011, 6'b000000, 0);
      expect_st(AC, "R8");
      rst = 1'b1;
      tick();
      rst = 1'b0;
      expect_st(F, "R1");
   endtask

   initial begin
      repeat (3) @(posedge clk);
      t_reset_initial();
      t_alu_reg();
      t_shift(1'b1);
      t_shift(1'b0);
      t_alui();
      t_testi();
      t_load(2, 3);
      t_load(0, 0);
      t_store(2);
      t_store(0);
      t_branch(6'b000100, 1'b1, 1);
      t_branch(6'b000100, 1'b0, 0);
      t_branch(6'b000101, 1'b0, 1);
      t_branch(6'b000101, 1'b1, 0);
      t_jr();
      t_jalr();
      t_unknown(6'b111111, 6'b000000);
      t_unknown(6'b000000, 6'b000001);
      t_reset_mid();
      expect_st(F, "R2");
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual run still busy expected finished");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule